// File: doc/BRIEF.md
# Interrupt Pin Redirection Router

This block sits between a bank of external interrupt lines and the message fabric that carries interrupts to processors. Each pin owns a programmable redirection entry that describes where and how its interrupt is sent. The entry holds a vector, a delivery mode, a destination mode, a destination, a trigger mode, a mask and a remote-pending flag. The block keeps one request bit per pin. On each cycle it picks the lowest-numbered pin that is allowed to fire and emits one delivery message on a valid/ready port.

Edge-triggered pins fire once per rising edge, and only if the pin is unmasked when the edge arrives. Level-triggered pins follow their input. After a level pin has been delivered, its remote-pending flag blocks any further delivery until an end-of-interrupt broadcast carries that entry's vector. When an entry uses the external-interrupt delivery mode, the vector in its message comes from a separate legacy-controller vector input. Entries are written and read as two 32-bit halves through a simple side port.

Top module: `irq_redirect_router`

## Requirements
- R1: A pin is delivered only when its request bit is set, its entry is unmasked (bit 16 = 0) and, for a level pin, its remote-pending flag is clear. The message appears on the second rising clock edge after the input change, or later under backpressure.
- R2: Delivering an edge pin (bit 15 = 0) clears its request bit, so one edge produces exactly one message. Delivering a level pin (bit 15 = 1) sets its remote-pending flag (bit 14) and leaves the request bit set.
- R3: A level pin's request bit follows its input, regardless of the mask. While remote-pending is set the pin is not delivered again. Once the input is low, the pin is not delivered.
- R4: A rising edge on an edge pin whose entry is masked is discarded. Unmasking the entry later produces no message.
- R5: An end-of-interrupt with vector V clears remote-pending on every entry whose flag is set and whose vector field (bits 7:0) equals V. Each such pin is delivered again if it is still requested and unmasked. An end-of-interrupt with any other vector changes nothing.
- R6: When an entry's delivery mode (bits 10:8) is 3'b111, the message vector is the value of the legacy vector input in the cycle the message is loaded. Every other mode sends the entry's vector field.
- R7: Input 0 drives pin 2 (ORed with input 2). Every other input n drives pin n. Pin 0 never receives a request.
- R8: Each entry write replaces one 32-bit half (high half selects bits 63:32), but remote-pending cannot be written and reserved bits read as zero. A pending, unmasked, eligible pin is delivered right after the write that unmasks it.
- R9: When several pins are eligible, the lowest index goes first. While the message is valid and not accepted, every message field holds steady and no other pin is taken.
- R10: After reset every entry reads low half 32'h0001_0000 and high half 0, all request bits are clear, and no message is valid.
- R11: The message carries destination from bits 63:56, destination mode from bit 11, delivery mode from bits 10:8 and trigger mode from bit 15 of the chosen entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_PINS | External interrupt input lines |
| cfgWe | input | 1 | Entry half write strobe |
| cfgIdx | input | IDX_W | Entry index to write |
| cfgHi | input | 1 | 1 selects bits 63:32, 0 selects bits 31:0 |
| cfgWdata | input | 32 | Write data for the selected half |
| rdIdx | input | IDX_W | Entry index to read |
| rdHi | input | 1 | Half select for the read |
| rdData | output | 32 | Combinational read of the selected half |
| eoiValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiVector | input | 8 | Vector carried by the end-of-interrupt |
| legacyVector | input | 8 | Vector supplied for external-interrupt mode |
| msgValid | output | 1 | Delivery message valid |
| msgReady | input | 1 | Receiver accepts the message |
| msgDest | output | 8 | Destination |
| msgDestMode | output | 1 | Destination mode (1 = logical) |
| msgDelivMode | output | 3 | Delivery mode |
| msgVector | output | 8 | Interrupt vector |
| msgTrigger | output | 1 | Trigger mode (1 = level) |

## Verification
The bound checker checks on every cycle that a taken pin is requested, unmasked and not blocked by remote-pending. It also checks that a taken level pin ends with its flag set, that a stalled message keeps all its fields, and that external-interrupt messages carry the sampled legacy vector. It further checks that a masked edge never creates a request and that pin 0 stays idle. Only the bench's scenarios show the effects that span several events. These include that an edge pin delivers once, that masked edges are lost for good, and that end-of-interrupt releases exactly the entries with the matching vector, in ascending order. They also include that the remote flag resists writes, and that the vector and destination of each message match what software programmed.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DM_W   = 3;
  localparam int HALF_W = 32;

  localparam logic [DM_W-1:0] DM_EXTINT = 3'b111;

  // Bit positions are fixed by software programming of each entry.
  typedef struct packed {
    logic [DEST_W-1:0] dest;        // 63:56
    logic [38:0]       rsvdHi;      // 55:17
    logic              masked;      // 16
    logic              levelTrig;   // 15
    logic              remotePend;  // 14
    logic [1:0]        rsvdLo;      // 13:12
    logic              logicalDest; // 11
    logic [DM_W-1:0]   delivMode;   // 10:8
    logic [VEC_W-1:0]  vector;      // 7:0
  } redir_entry_t;

  localparam redir_entry_t ENTRY_RESET = '{
    dest: '0, rsvdHi: '0, masked: 1'b1, levelTrig: 1'b0, remotePend: 1'b0,
    rsvdLo: '0, logicalDest: 1'b0, delivMode: '0, vector: '0
  };

  typedef struct packed {
    logic load;      // take the chosen pin into the message register
    logic eoiApply;  // apply the end-of-interrupt vector this cycle
  } ctrl_strobe_t;

endpackage

// File: rtl/irq_router_datapath.sv
module irq_router_datapath
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS   = 24,
  parameter int IDX_W      = 5,
  parameter int LEGACY_SRC = 0,
  parameter int LEGACY_PIN = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PINS-1:0]  irqIn,
  input  logic                 cfgWe,
  input  logic [IDX_W-1:0]     cfgIdx,
  input  logic                 cfgHi,
  input  logic [HALF_W-1:0]    cfgWdata,
  input  logic [IDX_W-1:0]     rdIdx,
  input  logic                 rdHi,
  output logic [HALF_W-1:0]    rdData,
  input  logic [VEC_W-1:0]     eoiVector,
  input  logic [VEC_W-1:0]     legacyVector,
  input  ctrl_strobe_t         strb,
  input  logic [IDX_W-1:0]     pickIdx,
  output logic [NUM_PINS-1:0]  reqVec,
  output logic [NUM_PINS-1:0]  maskVec,
  output logic [NUM_PINS-1:0]  levelVec,
  output logic [NUM_PINS-1:0]  remoteVec,
  output logic [DEST_W-1:0]    msgDest,
  output logic                 msgDestMode,
  output logic [DM_W-1:0]      msgDelivMode,
  output logic [VEC_W-1:0]     msgVector,
  output logic                 msgTrigger
);

  logic [NUM_PINS-1:0] pinLvl;
  redir_entry_t        tblView [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    // Input routing: the legacy source line folds onto the legacy pin.
    if (p == LEGACY_PIN) begin : g_fold
      assign pinLvl[p] = irqIn[p] | irqIn[LEGACY_SRC];
    end else if (p == LEGACY_SRC) begin : g_dead
      assign pinLvl[p] = 1'b0;
    end else begin : g_direct
      assign pinLvl[p] = irqIn[p];
    end

    redir_entry_t ent;
    redir_entry_t wrVal;
    logic         prevLvl;
    logic         req;
    logic         wrHit;
    logic         eoiHit;
    logic         pickHit;
    logic         edgeSeen;

    always_comb begin
      wrHit    = cfgWe && (cfgIdx == IDX_W'(p));
      eoiHit   = strb.eoiApply && ent.remotePend && (ent.vector == eoiVector);
      pickHit  = strb.load && (pickIdx == IDX_W'(p));
      edgeSeen = pinLvl[p] & ~prevLvl;
      wrVal    = ent;
      if (cfgHi) wrVal[63:32] = cfgWdata;
      else       wrVal[31:0]  = cfgWdata;
      wrVal.rsvdHi     = '0;
      wrVal.rsvdLo     = '0;
      wrVal.remotePend = ent.remotePend;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ent     <= ENTRY_RESET;
        prevLvl <= 1'b0;
        req     <= 1'b0;
      end else begin
        prevLvl <= pinLvl[p];
        if (wrHit) ent <= wrVal;
        ent.remotePend <= (ent.remotePend & ~eoiHit) | (pickHit & ent.levelTrig);
        if (ent.levelTrig) req <= pinLvl[p];
        else               req <= (req & ~pickHit) | (edgeSeen & ~ent.masked);
      end
    end

    assign tblView[p]   = ent;
    assign reqVec[p]    = req;
    assign maskVec[p]   = ent.masked;
    assign levelVec[p]  = ent.levelTrig;
    assign remoteVec[p] = ent.remotePend;
  end

  redir_entry_t sel;
  assign sel = tblView[pickIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgDest      <= '0;
      msgDestMode  <= 1'b0;
      msgDelivMode <= '0;
      msgVector    <= '0;
      msgTrigger   <= 1'b0;
    end else if (strb.load) begin
      msgDest      <= sel.dest;
      msgDestMode  <= sel.logicalDest;
      msgDelivMode <= sel.delivMode;
      msgVector    <= (sel.delivMode == DM_EXTINT) ? legacyVector : sel.vector;
      msgTrigger   <= sel.levelTrig;
    end
  end

  always_comb begin
    rdData = '0;
    if (int'(rdIdx) < NUM_PINS) begin
      rdData = rdHi ? tblView[rdIdx][63:32] : tblView[rdIdx][31:0];
    end
  end

endmodule

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] reqVec,
  input  logic [NUM_PINS-1:0] maskVec,
  input  logic [NUM_PINS-1:0] levelVec,
  input  logic [NUM_PINS-1:0] remoteVec,
  input  logic                eoiValid,
  input  logic                msgReady,
  output logic                msgValid,
  output ctrl_strobe_t        strb,
  output logic [IDX_W-1:0]    pickIdx
);

  logic [NUM_PINS-1:0] eligVec;
  logic                anyElig;
  logic                slotFree;

  assign eligVec  = reqVec & ~maskVec & ~(levelVec & remoteVec);
  assign slotFree = !msgValid || msgReady;

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    pickIdx = '0;
    anyElig = 1'b0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (eligVec[i]) begin
        pickIdx = IDX_W'(i);
        anyElig = 1'b1;
      end
    end
  end

  always_comb begin
    strb.load     = slotFree && anyElig;
    strb.eoiApply = eoiValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          msgValid <= 1'b0;
    else if (strb.load) msgValid <= 1'b1;
    else if (msgReady)  msgValid <= 1'b0;
  end

endmodule

// File: rtl/irq_redirect_router.sv
module irq_redirect_router
  import irq_router_pkg::*;
#(
  parameter  int NUM_PINS   = 24,
  parameter  int LEGACY_SRC = 0,
  parameter  int LEGACY_PIN = 2,
  localparam int IDX_W      = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] irqIn,
  input  logic                cfgWe,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic                cfgHi,
  input  logic [31:0]         cfgWdata,
  input  logic [IDX_W-1:0]    rdIdx,
  input  logic                rdHi,
  output logic [31:0]         rdData,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  input  logic [7:0]          legacyVector,
  output logic                msgValid,
  input  logic                msgReady,
  output logic [7:0]          msgDest,
  output logic                msgDestMode,
  output logic [2:0]          msgDelivMode,
  output logic [7:0]          msgVector,
  output logic                msgTrigger
);

  ctrl_strobe_t        strb;
  logic [IDX_W-1:0]    pickIdx;
  logic [NUM_PINS-1:0] reqVec;
  logic [NUM_PINS-1:0] maskVec;
  logic [NUM_PINS-1:0] levelVec;
  logic [NUM_PINS-1:0] remoteVec;

  irq_router_ctrl #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqVec(reqVec), .maskVec(maskVec), .levelVec(levelVec), .remoteVec(remoteVec),
    .eoiValid(eoiValid), .msgReady(msgReady), .msgValid(msgValid),
    .strb(strb), .pickIdx(pickIdx)
  );

  irq_router_datapath #(
    .NUM_PINS(NUM_PINS), .IDX_W(IDX_W),
    .LEGACY_SRC(LEGACY_SRC), .LEGACY_PIN(LEGACY_PIN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgHi(cfgHi), .cfgWdata(cfgWdata),
    .rdIdx(rdIdx), .rdHi(rdHi), .rdData(rdData),
    .eoiVector(eoiVector), .legacyVector(legacyVector),
    .strb(strb), .pickIdx(pickIdx),
    .reqVec(reqVec), .maskVec(maskVec), .levelVec(levelVec), .remoteVec(remoteVec),
    .msgDest(msgDest), .msgDestMode(msgDestMode), .msgDelivMode(msgDelivMode),
    .msgVector(msgVector), .msgTrigger(msgTrigger)
  );

endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
  parameter int NUM_PINS   = 24,
  parameter int IDX_W      = 5,
  parameter int LEGACY_SRC = 0
) (
  input logic                clk,
  input logic                rstN,
  input logic                load,
  input logic [IDX_W-1:0]    pickIdx,
  input logic [NUM_PINS-1:0] reqVec,
  input logic [NUM_PINS-1:0] maskVec,
  input logic [NUM_PINS-1:0] levelVec,
  input logic [NUM_PINS-1:0] remoteVec,
  input logic                msgValid,
  input logic                msgReady,
  input logic [7:0]          msgDest,
  input logic                msgDestMode,
  input logic [2:0]          msgDelivMode,
  input logic [7:0]          msgVector,
  input logic                msgTrigger,
  input logic [7:0]          legacyVector
);

  a_r1_taken_is_eligible: assert property (@(posedge clk) disable iff (!rstN)
    load |-> reqVec[pickIdx] && !maskVec[pickIdx] && !(levelVec[pickIdx] && remoteVec[pickIdx]));

  a_r2_level_sets_remote: assert property (@(posedge clk) disable iff (!rstN)
    load && levelVec[pickIdx] |=> remoteVec[$past(pickIdx)]);

  a_r4_masked_edge_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec & ~$past(reqVec) & ~$past(levelVec) & $past(maskVec)) == '0);

  a_r6_legacy_vector: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (msgDelivMode != 3'b111) || (msgVector == $past(legacyVector)));

  a_r7_source_pin_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqVec[LEGACY_SRC]);

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgDest) && $stable(msgDestMode)
      && $stable(msgDelivMode) && $stable(msgVector) && $stable(msgTrigger));

endmodule

bind irq_redirect_router irq_router_checker #(
  .NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .LEGACY_SRC(LEGACY_SRC)
) u_chk (
  .clk(clk), .rstN(rstN), .load(strb.load), .pickIdx(pickIdx),
  .reqVec(reqVec), .maskVec(maskVec), .levelVec(levelVec), .remoteVec(remoteVec),
  .msgValid(msgValid), .msgReady(msgReady), .msgDest(msgDest),
  .msgDestMode(msgDestMode), .msgDelivMode(msgDelivMode), .msgVector(msgVector),
  .msgTrigger(msgTrigger), .legacyVector(legacyVector)
);

// File: tb/test_irq_redirect_router.sv
module test_irq_redirect_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] irqIn = '0;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgIdx = '0;
  logic        cfgHi = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [4:0]  rdIdx = '0;
  logic        rdHi = 1'b0;
  logic [31:0] rdData;
  logic        eoiValid = 1'b0;
  logic [7:0]  eoiVector = '0;
  logic [7:0]  legacyVector = '0;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [7:0]  msgDest;
  logic        msgDestMode;
  logic [2:0]  msgDelivMode;
  logic [7:0]  msgVector;
  logic        msgTrigger;

  int  nChk = 0;
  int  nErr = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  irq_redirect_router i_irq_redirect_router (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgHi(cfgHi), .cfgWdata(cfgWdata),
    .rdIdx(rdIdx), .rdHi(rdHi), .rdData(rdData),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .legacyVector(legacyVector),
    .msgValid(msgValid), .msgReady(msgReady), .msgDest(msgDest),
    .msgDestMode(msgDestMode), .msgDelivMode(msgDelivMode),
    .msgVector(msgVector), .msgTrigger(msgTrigger)
  );

  typedef struct packed {
    logic [4:0] inp;
    logic [7:0] vec;
    logic [2:0] dm;
    logic       lg;
    logic [7:0] dst;
    logic [7:0] leg;
    logic [7:0] expVec;
  } row_t;

  localparam int NROWS = 5;
  localparam row_t ROWS [NROWS] = '{
    '{5'd5,  8'h31, 3'd0, 1'b0, 8'h01, 8'h00, 8'h31},
    '{5'd0,  8'h40, 3'd1, 1'b1, 8'h0F, 8'h00, 8'h40},
    '{5'd23, 8'hFE, 3'd7, 1'b0, 8'h80, 8'h5A, 8'h5A},
    '{5'd1,  8'h22, 3'd4, 1'b0, 8'hFF, 8'h00, 8'h22},
    '{5'd12, 8'h10, 3'd2, 1'b1, 8'h03, 8'hC3, 8'h10}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
  endtask

  task automatic wrEntry(input int pin, input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 5'(pin); cfgHi = 1'b0; cfgWdata = lo;
    @(negedge clk);
    cfgHi = 1'b1; cfgWdata = hi;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic wrHalf(input int pin, input logic hiSel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 5'(pin); cfgHi = hiSel; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic rdWord(input int pin, input logic hiSel, output logic [31:0] v);
    @(negedge clk);
    rdIdx = 5'(pin); rdHi = hiSel;
    #1 v = rdData;
  endtask

  task automatic waitMsg(input int maxCyc, output logic got);
    got = 1'b0;
    for (int i = 0; i < maxCyc && !got; i++) begin
      @(negedge clk);
      if (msgValid) got = 1'b1;
    end
  endtask

  task automatic consume();
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
  endtask

  task automatic noMsg(input int n, input string tag);
    logic seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (msgValid) seen = 1'b1;
    end
    chk(tag, seen, 1'b0);
  endtask

  task automatic pulse(input int inp);
    @(negedge clk);
    irqIn[inp] = 1'b1;
    @(negedge clk);
    irqIn[inp] = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoiValid = 1'b1; eoiVector = v;
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic        got;
    logic [31:0] v;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    @(negedge clk);
    chk("R10 no message after reset", msgValid, 1'b0);
    rdWord(5, 1'b0, v);
    chk("R10 entry low reset value", v, 32'h0001_0000);
    rdWord(5, 1'b1, v);
    chk("R10 entry high reset value", v, 32'h0);

    // R7: pin 0 armed with a distinct vector; it must never fire
    wrEntry(0, {20'h0, 1'b0, 3'd0, 8'hE0}, 32'h0);

    // Table walk: edge pins, R1 R2 R6 R7 R11
    for (int r = 0; r < NROWS; r++) begin
      int pin;
      pin = (ROWS[r].inp == 5'd0) ? 2 : int'(ROWS[r].inp);
      wrEntry(pin, {20'h0, ROWS[r].lg, ROWS[r].dm, ROWS[r].vec}, {ROWS[r].dst, 24'h0});
      legacyVector = ROWS[r].leg;
      pulse(int'(ROWS[r].inp));
      waitMsg(8, got);
      chk("R1 edge delivered", got, 1'b1);
      chk("R11 destination", msgDest, ROWS[r].dst);
      chk("R11 destination mode", msgDestMode, ROWS[r].lg);
      chk("R11 delivery mode", msgDelivMode, ROWS[r].dm);
      chk("R11 trigger edge", msgTrigger, 1'b0);
      chk("R6 R7 vector", msgVector, ROWS[r].expVec);
      consume();
      noMsg(5, "R2 edge delivered once");
    end
    legacyVector = 8'h00;

    // R8: half writes, remote flag not writable, reserved bits zero
    wrHalf(20, 1'b0, 32'hFFFF_4033);
    rdWord(20, 1'b0, v);
    chk("R8 remote and reserved not written", v, 32'h0001_0033);
    wrHalf(20, 1'b1, 32'hAB00_0000);
    rdWord(20, 1'b1, v);
    chk("R8 high half written", v, 32'hAB00_0000);
    rdWord(20, 1'b0, v);
    chk("R8 low half preserved", v, 32'h0001_0033);

    // R4: edge on masked pin is lost
    pulse(7);
    noMsg(4, "R4 masked edge no message");
    wrEntry(7, 32'h0000_0077, 32'h0);
    noMsg(6, "R4 unmask after dropped edge");

    // R3 R8 R5 R2: level pin
    wrEntry(8, 32'h0001_8088, 32'h0);
    @(negedge clk); irqIn[8] = 1'b1;
    noMsg(4, "R1 masked level pin idle");
    wrHalf(8, 1'b0, 32'h0000_8088);
    waitMsg(4, got);
    chk("R8 unmask delivers pending", got, 1'b1);
    chk("R11 trigger level", msgTrigger, 1'b1);
    chk("R8 level vector", msgVector, 8'h88);
    rdWord(8, 1'b0, v);
    chk("R2 remote set after level delivery", v[14], 1'b1);
    consume();
    noMsg(6, "R3 no redelivery while remote set");
    eoi(8'h87);
    noMsg(4, "R5 mismatched eoi no effect");
    rdWord(8, 1'b0, v);
    chk("R5 remote kept on mismatch", v[14], 1'b1);
    eoi(8'h88);
    waitMsg(6, got);
    chk("R5 eoi redelivers", got, 1'b1);
    chk("R5 redelivered vector", msgVector, 8'h88);
    consume();
    @(negedge clk); irqIn[8] = 1'b0;
    repeat (3) @(negedge clk);
    eoi(8'h88);
    noMsg(5, "R3 lowered level not delivered");
    rdWord(8, 1'b0, v);
    chk("R5 remote cleared by eoi", v[14], 1'b0);

    // R5 R9: shared vector on two level pins
    wrEntry(10, 32'h0000_8055, 32'h0A00_0000);
    wrEntry(11, 32'h0000_8055, 32'h0B00_0000);
    @(negedge clk); irqIn[11] = 1'b1; irqIn[10] = 1'b1;
    waitMsg(6, got);
    chk("R9 lower pin first", msgDest, 8'h0A);
    consume();
    waitMsg(4, got);
    chk("R9 higher pin second", msgDest, 8'h0B);
    consume();
    noMsg(4, "R3 both remote blocked");
    eoi(8'h55);
    waitMsg(6, got);
    chk("R5 eoi releases first entry", msgDest, 8'h0A);
    consume();
    waitMsg(4, got);
    chk("R5 eoi releases second entry", msgDest, 8'h0B);
    consume();
    @(negedge clk); irqIn[10] = 1'b0; irqIn[11] = 1'b0;
    repeat (3) @(negedge clk);
    eoi(8'h55);
    noMsg(4, "R3 idle after release");

    // R9: backpressure and ordering of simultaneous edges
    wrEntry(14, 32'h0000_00D4, 32'h0);
    wrEntry(13, 32'h0000_00D3, 32'h0);
    @(negedge clk); irqIn[13] = 1'b1; irqIn[14] = 1'b1;
    @(negedge clk); irqIn[13] = 1'b0; irqIn[14] = 1'b0;
    waitMsg(6, got);
    chk("R9 first of simultaneous edges", msgVector, 8'hD3);
    begin
      logic held = 1'b1;
      repeat (5) begin
        @(negedge clk);
        if (!msgValid || msgVector !== 8'hD3) held = 1'b0;
      end
      chk("R9 message held while stalled", held, 1'b1);
    end
    consume();
    waitMsg(4, got);
    chk("R9 second edge follows", msgVector, 8'hD4);
    consume();
    noMsg(5, "R2 both edges served once");

    done = 1;
    summary();
    $finish;
  end

endmodule